// File: doc/BRIEF.md
# Audio Codec Register Bring-Up Sequencer

This block configures an audio codec once the chip leaves reset. When it is started, it writes a fixed, ordered set of ten 16-bit configuration words to the codec over a two-wire I2C bus. The block is the only master on that bus and it only writes. Each word travels as its own bus transaction: a start condition, the codec's write address byte, the high byte of the word, the low byte of the word, and a stop condition.

The block checks the acknowledge after every byte. If all ten transactions are acknowledged, the block reports completion. The last word written is the one that activates the codec. If a byte is not acknowledged, the block closes that transaction with a stop condition, records which table entry failed, and halts.

Both bus lines are open-drain. The block only reports whether it wants each line pulled low, and the pad logic outside the block turns that into a pull-down or a released line. Because the block has no streaming data path, every pin is a plain control or status signal.

Top module: `codec_init_seq`

## Requirements
- R1: After reset, and whenever `busy_o` is low, neither bus line is pulled low, and `busy_o`, `done_o` and `err_o` are low until the first start.
- R2: A one-cycle `start_i` pulse while not busy raises `busy_o` on the next cycle and clears `done_o` and `err_o`. `busy_o` stays high until `done_o` or `err_o` rises, and `busy_o` never rises without a start pulse in the previous cycle.
- R3: Every transaction has five parts in this order: a start condition, the byte 0x34 (7-bit address 0x1A followed by a write bit of 0), the high byte of the word, the low byte of the word, and a stop condition. All bytes are sent most significant bit first.
- R4: The words go out in ascending entry order, entries 0 to 9. Entry k has high byte 2·k. The low bytes for entries 0 to 9 are 1F, 1F, 7F, 7F, 12, 06, 00, 01, 02, 01, so entry 9, the activate word 0x1201, is always the final transaction.
- R5: SDA changes only while SCL is low, with two exceptions. A start condition is SDA falling while SCL is high, and a stop condition is SDA rising while SCL is high. Exactly one start and one stop surround each transaction.
- R6: With QDIV = max(2, CLK_HZ/(4·SCL_HZ)), SCL stays high for exactly 2·QDIV clock cycles during every data or acknowledge bit.
- R7: During the ninth clock of each byte the block releases SDA and samples it while SCL is high. A low level counts as an acknowledge.
- R8: If a byte is not acknowledged, the block sends a stop condition and sends no further bytes or transactions. It then raises `err_o` and sets `err_idx_o` to the failing entry. `err_o` stays high until the next start.
- R9: `done_o` rises only after the stop condition of the tenth acknowledged transaction, and it stays high until the next start.
- R10: A `start_i` pulse while `busy_o` is high has no effect, and the running sequence completes unchanged.
- R11: An entry index outside 0 to 9 reads as the filler word 0xABCD, and the filler word is never transmitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Pulse that starts the write sequence from entry 0 |
| sda_i | input | 1 | Level sensed on the SDA line |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | All ten words written and acknowledged |
| err_o | output | 1 | Sticky flag: an acknowledge was missing |
| err_idx_o | output | 4 | Entry whose transaction failed |

## Verification
The assertions take two things for granted about the inputs. First, `start_i` is synchronous to `clk`. Second, `sda_i` reflects the wired-AND of this block's drive and a single target device that pulls SDA low only in the acknowledge slot and never holds SCL low. The bench's target model obeys both rules: it asserts its pull on the SCL fall that ends the eighth bit and releases it on the following fall, and it never stretches the clock. Start pulses are one cycle wide, and the bench deliberately places one of them in the middle of a running sequence.

// File: rtl/codec_init_pkg.sv
package codec_init_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_BYTE  = 2'd1,
    OP_STOP  = 2'd2
  } i2c_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_ISSUE = 3'd1,
    SQ_WAIT  = 3'd2,
    SQ_DONE  = 3'd3,
    SQ_HALT  = 3'd4
  } seq_state_e;

  typedef enum logic [2:0] {
    ST_START = 3'd0,
    ST_ADDR  = 3'd1,
    ST_HI    = 3'd2,
    ST_LO    = 3'd3,
    ST_STOP  = 3'd4
  } txn_step_e;

  localparam int unsigned CFG_COUNT  = 10;
  localparam int unsigned IDX_W      = 4;
  localparam logic [15:0] CFG_FILLER = 16'hABCD;

endpackage

// File: rtl/codec_cfg_rom.sv
module codec_cfg_rom
  import codec_init_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic [15:0]      word_o
);

  always_comb begin
    case (idx_i)
      4'd0:    word_o = 16'h001F;
      4'd1:    word_o = 16'h021F;
      4'd2:    word_o = 16'h047F;
      4'd3:    word_o = 16'h067F;
      4'd4:    word_o = 16'h0812;
      4'd5:    word_o = 16'h0A06;
      4'd6:    word_o = 16'h0C00;
      4'd7:    word_o = 16'h0E01;
      4'd8:    word_o = 16'h1002;
      4'd9:    word_o = 16'h1201;
      default: word_o = CFG_FILLER;
    endcase
  end

endmodule

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int unsigned QDIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);

  localparam int unsigned CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (clr_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
  import codec_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       qtick_i,
  input  logic       cmd_valid_i,
  output logic       cmd_ready_o,
  input  i2c_op_e    cmd_op_i,
  input  logic [7:0] cmd_byte_i,
  output logic       rsp_valid_o,
  output logic       rsp_ack_o,
  input  logic       sda_i,
  output logic       scl_low_o,
  output logic       sda_low_o,
  output logic       ack_slot_o
);

  logic       act_q;
  i2c_op_e    op_q;
  logic [1:0] q_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       ack_q;
  logic       scl_hi_q, sda_hi_q;
  logic       scl_hi_d, sda_hi_d;
  logic       in_ack;

  assign cmd_ready_o = !act_q;
  assign in_ack      = act_q && (op_q == OP_BYTE) && (bit_q == 4'd8);
  assign ack_slot_o  = in_ack;

  // Line levels for the current quarter of the current element.
  always_comb begin
    scl_hi_d = 1'b1;
    sda_hi_d = 1'b1;
    case (op_q)
      OP_START: begin
        scl_hi_d = (q_q != 2'd3);
        sda_hi_d = (q_q < 2'd2);
      end
      OP_BYTE: begin
        scl_hi_d = (q_q == 2'd1) || (q_q == 2'd2);
        sda_hi_d = (bit_q == 4'd8) ? 1'b1 : sh_q[7];
      end
      OP_STOP: begin
        scl_hi_d = (q_q != 2'd0);
        sda_hi_d = (q_q == 2'd3);
      end
      default: begin
        scl_hi_d = 1'b1;
        sda_hi_d = 1'b1;
      end
    endcase
  end

  // Lines hold their level between elements so SCL stays low mid-transaction.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_hi_q <= 1'b1;
      sda_hi_q <= 1'b1;
    end else if (act_q) begin
      scl_hi_q <= scl_hi_d;
      sda_hi_q <= sda_hi_d;
    end
  end

  assign scl_low_o = !scl_hi_q;
  assign sda_low_o = !sda_hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q       <= 1'b0;
      op_q        <= OP_START;
      q_q         <= 2'd0;
      bit_q       <= 4'd0;
      sh_q        <= 8'h00;
      ack_q       <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_ack_o   <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      if (!act_q) begin
        if (cmd_valid_i) begin
          act_q <= 1'b1;
          op_q  <= cmd_op_i;
          sh_q  <= cmd_byte_i;
          q_q   <= 2'd0;
          bit_q <= 4'd0;
          ack_q <= 1'b0;
        end
      end else if (qtick_i) begin
        if (in_ack && (q_q == 2'd1)) ack_q <= !sda_i;
        q_q <= q_q + 2'd1;
        if (q_q == 2'd3) begin
          if ((op_q == OP_BYTE) && (bit_q != 4'd8)) begin
            sh_q  <= {sh_q[6:0], 1'b0};
            bit_q <= bit_q + 4'd1;
          end else begin
            act_q       <= 1'b0;
            rsp_valid_o <= 1'b1;
            rsp_ack_o   <= (op_q == OP_BYTE) ? ack_q : 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/codec_init_seq.sv
module codec_init_seq
  import codec_init_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned SCL_HZ   = 100_000,
  parameter logic [6:0]  DEV_ADDR = 7'h1A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             sda_i,
  output logic             scl_low_o,
  output logic             sda_low_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [IDX_W-1:0] err_idx_o
);

  localparam int unsigned QRAW = CLK_HZ / (4 * SCL_HZ);
  localparam int unsigned QDIV = (QRAW < 2) ? 2 : QRAW;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CFG_COUNT - 1);

  seq_state_e       st_q;
  txn_step_e        step_q;
  logic [IDX_W-1:0] idx_q;
  logic             nack_q;
  logic [15:0]      cfg_word;
  logic             qtick, cmd_valid, cmd_ready, rsp_valid, rsp_ack, ack_slot;
  i2c_op_e          cmd_op;
  logic [7:0]       cmd_byte;

  codec_cfg_rom u_rom (
    .idx_i  (idx_q),
    .word_o (cfg_word)
  );

  i2c_qtick #(.QDIV(QDIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cmd_valid && cmd_ready),
    .tick_o (qtick)
  );

  i2c_wr_engine u_eng (
    .clk         (clk),
    .rst_n       (rst_n),
    .qtick_i     (qtick),
    .cmd_valid_i (cmd_valid),
    .cmd_ready_o (cmd_ready),
    .cmd_op_i    (cmd_op),
    .cmd_byte_i  (cmd_byte),
    .rsp_valid_o (rsp_valid),
    .rsp_ack_o   (rsp_ack),
    .sda_i       (sda_i),
    .scl_low_o   (scl_low_o),
    .sda_low_o   (sda_low_o),
    .ack_slot_o  (ack_slot)
  );

  assign cmd_valid = (st_q == SQ_ISSUE);

  always_comb begin
    case (step_q)
      ST_START: cmd_op = OP_START;
      ST_STOP:  cmd_op = OP_STOP;
      default:  cmd_op = OP_BYTE;
    endcase
    case (step_q)
      ST_ADDR: cmd_byte = {DEV_ADDR, 1'b0};
      ST_HI:   cmd_byte = cfg_word[15:8];
      ST_LO:   cmd_byte = cfg_word[7:0];
      default: cmd_byte = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      step_q    <= ST_START;
      idx_q     <= '0;
      nack_q    <= 1'b0;
      err_idx_o <= '0;
    end else begin
      case (st_q)
        SQ_ISSUE: if (cmd_ready) st_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (rsp_valid) begin
            st_q <= SQ_ISSUE;
            if (step_q == ST_STOP) begin
              step_q <= ST_START;
              if (nack_q) begin
                st_q      <= SQ_HALT;
                err_idx_o <= idx_q;
              end else if (idx_q == LAST_IDX) begin
                st_q <= SQ_DONE;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else if ((step_q != ST_START) && !rsp_ack) begin
              nack_q <= 1'b1;
              step_q <= ST_STOP;
            end else begin
              step_q <= txn_step_e'(step_q + 3'd1);
            end
          end
        end
        default: begin
          if (start_i) begin
            st_q      <= SQ_ISSUE;
            step_q    <= ST_START;
            idx_q     <= '0;
            nack_q    <= 1'b0;
            err_idx_o <= '0;
          end
        end
      endcase
    end
  end

  assign busy_o = (st_q == SQ_ISSUE) || (st_q == SQ_WAIT);
  assign done_o = (st_q == SQ_DONE);
  assign err_o  = (st_q == SQ_HALT);

endmodule

// File: rtl/codec_init_chk.sv
module codec_init_chk
  import codec_init_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_i,
  input logic             done_i,
  input logic             err_i,
  input logic             scl_low_i,
  input logic             sda_low_i,
  input logic             ack_slot_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [15:0]      word_i
);

  p_lines_free_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_i |-> (!scl_low_i && !sda_low_i));

  p_busy_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_i) |-> $past(start_i));

  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_i <= IDX_W'(CFG_COUNT - 1));

  p_ack_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_slot_i && $past(ack_slot_i)) |-> !sda_low_i);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_i && !start_i) |=> err_i);

  p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !start_i) |=> done_i);

  p_no_filler_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (word_i != CFG_FILLER));

endmodule

bind codec_init_seq codec_init_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_i     (busy_o),
  .done_i     (done_o),
  .err_i      (err_o),
  .scl_low_i  (scl_low_o),
  .sda_low_i  (sda_low_o),
  .ack_slot_i (ack_slot),
  .idx_i      (idx_q),
  .word_i     (cfg_word)
);

// File: tb/codec_init_seq_bench.sv
module codec_init_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 800;
  localparam int SCL_HZ     = 100;
  localparam int QDIV       = 2;

  logic       clk = 1'b0;
  logic       rst_n, start_i;
  logic       scl_low_o, sda_low_o, busy_o, done_o, err_o;
  logic [3:0] err_idx_o;
  logic       slv_pull = 1'b0;
  logic       bus_sda;

  int checks = 0;
  int errors = 0;

  // Target model state
  logic       rec_clear;
  int         nack_at;
  logic [7:0] rec [16][3];
  int         rec_n [16];
  int         txn_cnt, start_cnt, byte_total, cur_n, bitc, hcnt, bad_len;
  logic [7:0] shr;
  logic       pscl = 1'b1, psda = 1'b1;

  assign bus_sda = !(sda_low_o || slv_pull);

  always #(CLK_PERIOD / 2) clk = ~clk;

  codec_init_seq #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ), .DEV_ADDR(7'h1A)) u_codec_init_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .sda_i     (bus_sda),
    .scl_low_o (scl_low_o),
    .sda_low_o (sda_low_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .err_idx_o (err_idx_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int k);
    logic [7:0] lo;
    case (k)
      0, 1:    lo = 8'h1F;
      2, 3:    lo = 8'h7F;
      4:       lo = 8'h12;
      5:       lo = 8'h06;
      6:       lo = 8'h00;
      7:       lo = 8'h01;
      8:       lo = 8'h02;
      default: lo = 8'h01;
    endcase
    return {8'(2 * k), lo};
  endfunction

  // Bus target: decodes conditions and bits away from the active edge.
  always @(negedge clk) begin
    logic scl_s, sda_s;
    scl_s = !scl_low_o;
    sda_s = bus_sda;
    if (rec_clear) begin
      txn_cnt = 0; start_cnt = 0; byte_total = 0; cur_n = 0;
      bitc = 0; bad_len = 0; hcnt = 0; slv_pull = 1'b0;
    end else if (scl_s && pscl && psda && !sda_s) begin
      start_cnt++;
      bitc  = 0;
      cur_n = 0;
    end else if (scl_s && pscl && !psda && sda_s) begin
      if (txn_cnt < 16) rec_n[txn_cnt] = cur_n;
      txn_cnt++;
    end else if (scl_s && !pscl) begin
      hcnt = 1;
      if (bitc < 8) shr = {shr[6:0], sda_s};
      bitc++;
    end else if (!scl_s && pscl) begin
      if (bitc >= 1 && bitc <= 9 && hcnt != 2 * QDIV) bad_len++;
      if (bitc == 8) begin
        if (txn_cnt < 16 && cur_n < 3) rec[txn_cnt][cur_n] = shr;
        cur_n++;
        slv_pull = (byte_total != nack_at);
        byte_total++;
      end else if (bitc == 9) begin
        slv_pull = 1'b0;
        bitc = 0;
      end
    end else if (scl_s && pscl) begin
      hcnt++;
    end
    pscl = scl_s;
    psda = sda_s;
  end

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic run_case(input int nack_pos, input bit poke_mid);
    @(posedge clk);
    rec_clear = 1'b1;
    nack_at   = nack_pos;
    @(posedge clk);
    rec_clear = 1'b0;
    pulse_start();
    chk(busy_o && !done_o && !err_o, "R2 busy after start", int'(busy_o), 1);
    if (poke_mid) begin
      while (txn_cnt < 3) @(negedge clk);
      pulse_start();
      chk(busy_o == 1'b1, "R10 start while busy", int'(busy_o), 1);
    end
    while (!(done_o || err_o)) @(negedge clk);
    chk(!busy_o, "R2 busy ends", int'(busy_o), 0);
    chk(!scl_low_o && !sda_low_o, "R1 lines released", int'({scl_low_o, sda_low_o}), 0);
    chk(bad_len == 0, "R6 SCL high time", bad_len, 0);
    if (nack_pos < 0) begin
      int filler;
      filler = 0;
      chk(done_o && !err_o, "R9 done", int'({done_o, err_o}), 2);
      chk(txn_cnt == 10, "R4 transaction count", txn_cnt, 10);
      chk(start_cnt == 10, "R5 start conditions", start_cnt, 10);
      for (int t = 0; t < 10; t++) begin
        chk(rec_n[t] == 3, "R3 bytes per transaction", rec_n[t], 3);
        chk(rec[t][0] == 8'h34, "R3 address byte", int'(rec[t][0]), 8'h34);
        chk({rec[t][1], rec[t][2]} == exp_word(t), "R4 word order",
            int'({rec[t][1], rec[t][2]}), int'(exp_word(t)));
        if ({rec[t][1], rec[t][2]} == 16'hABCD) filler++;
      end
      chk(filler == 0, "R11 filler never sent", filler, 0);
      chk({rec[9][1], rec[9][2]} == 16'h1201, "R4 activate last",
          int'({rec[9][1], rec[9][2]}), 16'h1201);
      repeat (60) @(negedge clk);
      chk(done_o && !busy_o, "R9 done held", int'(done_o), 1);
    end else begin
      int t;
      t = nack_pos / 3;
      chk(err_o && !done_o, "R8 error raised", int'({done_o, err_o}), 1);
      chk(int'(err_idx_o) == t, "R8 failing entry", int'(err_idx_o), t);
      chk(txn_cnt == t + 1, "R8 stop after missing ack", txn_cnt, t + 1);
      chk(rec_n[t] == nack_pos % 3 + 1, "R7 bytes before halt", rec_n[t], nack_pos % 3 + 1);
      chk(start_cnt == t + 1, "R5 start conditions", start_cnt, t + 1);
      chk(rec[t][0] == 8'h34, "R3 address byte", int'(rec[t][0]), 8'h34);
      repeat (150) @(negedge clk);
      chk(err_o && txn_cnt == t + 1 && start_cnt == t + 1, "R8 halted and sticky",
          txn_cnt, t + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual 0 expected 1 (sequence never finished)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    start_i   = 1'b0;
    rec_clear = 1'b0;
    nack_at   = -1;
    repeat (3) @(negedge clk);
    chk(!scl_low_o && !sda_low_o, "R1 lines in reset", int'({scl_low_o, sda_low_o}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!busy_o && !done_o && !err_o, "R1 status after reset",
        int'({busy_o, done_o, err_o}), 0);
    chk(!scl_low_o && !sda_low_o, "R1 lines idle", int'({scl_low_o, sda_low_o}), 0);
    run_case(-1, 1'b0);
    run_case(-1, 1'b1);
    for (int p = 0; p < 30; p++) run_case(p, 1'b0);
    run_case(-1, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule